// File: doc/BRIEF.md
# Multi-Channel Ramp ADC Digitizer

This block is the digital back end of a ramp (Wilkinson) converter that serves many channels at once. A start pulse clears one shared counter, and the counter then advances once per conversion clock while the analog ramp rises outside the block. The counter runs in reflected binary (Gray) code, so a snapshot taken at any moment is a single valid code.

Each channel watches its own end-of-ramp comparator through a two-stage synchronizer. On the first rising edge after start, the channel stores the current Gray count together with its gain-range flag. The entry goes into a results store addressed by channel and by the memory slice chosen at start. A channel that never fires before the counter reaches full scale is given the full-scale code with an overflow mark.

When the count wraps, the block pulses a done output for one clock and goes idle until the next start. A combinational read port returns any stored entry.

Top module: `wilkinson_digitizer`

## Requirements
- R1: After reset `convDone` is low and every stored entry reads back as code 0, gain 0, overflow 0.
- R2: A start pulse accepted while idle resets the count to 0 at that clock edge, and the count then increases by one per edge. A comparator rise applied before edge a (the start edge is edge 0) stores the count value a+1.
- R3: Stored codes and the running count use reflected binary code: the code for binary value b is b XOR (b >> 1), and consecutive counter values differ in at most one bit.
- R4: Only the first synchronized rising edge of a channel's comparator after a start is captured. Later edges in the same conversion leave the entry unchanged.
- R5: The `gainIn` bit of a channel is stored with its code, unchanged: 1 stays 1 and 0 stays 0.
- R6: A channel that does not capture by the edge at which the count is at full scale stores the code of 2^CODE_W-1 (MSB set, all other bits clear) with overflow = 1. Captured entries have overflow = 0.
- R7: `convDone` goes high for exactly one clock, after the edge at which the count at full scale is seen (edge 2^CODE_W after start). Counting then stops.
- R8: A start pulse during a conversion is ignored. It neither restarts the count nor changes the target slice.
- R9: The slice sampled at start selects the row that is written. Entries of other slices are not modified.
- R10: A comparator that is already high when the conversion starts produces no rising edge, so that channel ends with overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Active-low synchronous reset |
| startConv | input | 1 | Conversion start pulse |
| sliceSel | input | SLICE_W | Slice to be written, sampled at start |
| cmpIn | input | NUM_CH | End-of-ramp comparator outputs, asynchronous |
| gainIn | input | NUM_CH | Per-channel gain-range flag (1 = high gain) |
| rdCh | input | CH_W | Read channel address |
| rdSlice | input | SLICE_W | Read slice address |
| convDone | output | 1 | One-clock pulse at end of conversion |
| rdCode | output | CODE_W | Stored Gray code at the read address |
| rdGain | output | 1 | Stored gain flag at the read address |
| rdOvf | output | 1 | Stored overflow mark at the read address |

## Verification
The bench builds the block with a 4-bit code, 4 channels and 2 slices. At that size a full ramp takes 16 clocks, so the sweep can place comparator edges at every count position, including the last one, which lands too late and must produce an overflow.

Across the runs the bench alternates slices, gain patterns, refiring comparators, comparators held high before start, silent channels and mid-conversion start pulses. After every conversion it reads back the whole store and decodes each entry arithmetically.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
  typedef struct packed {
    logic clearCnt;
    logic countEn;
    logic finish;
  } wadcStrobes_t;
endpackage

// File: rtl/wadc_ctrl.sv
module wadc_ctrl
  import wadc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startConv,
  input  logic         cntAtMax,
  output wadcStrobes_t strobes,
  output logic         busy,
  output logic         convDone
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      convDone <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (!busy && startConv) begin
        busy <= 1'b1;
      end else if (busy && cntAtMax) begin
        busy     <= 1'b0;
        convDone <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clearCnt = !busy && startConv;
    strobes.countEn  = busy;
    strobes.finish   = busy && cntAtMax;
  end
endmodule

// File: rtl/wadc_datapath.sv
module wadc_datapath
  import wadc_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int NUM_CH     = 36,
  parameter int NUM_SLICES = 16,
  parameter int CH_W       = 6,
  parameter int SLICE_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  wadcStrobes_t        strobes,
  input  logic [SLICE_W-1:0]  sliceSel,
  input  logic [NUM_CH-1:0]   cmpIn,
  input  logic [NUM_CH-1:0]   gainIn,
  input  logic [CH_W-1:0]     rdCh,
  input  logic [SLICE_W-1:0]  rdSlice,
  output logic                cntAtMax,
  output logic [CODE_W-1:0]   grayCnt,
  output logic [CODE_W-1:0]   rdCode,
  output logic                rdGain,
  output logic                rdOvf
);
  localparam int ENTRY_W = CODE_W + 2;
  localparam logic [CODE_W-1:0] BIN_MAX   = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] GRAY_FULL = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0]  binCnt;
  logic [CODE_W-1:0]  binNext;
  logic [SLICE_W-1:0] activeSlice;
  logic [ENTRY_W-1:0] rdEntries [NUM_CH];

  // Shared counter: binary copy for the wrap test, registered Gray copy for capture
  always_comb begin
    binNext = strobes.clearCnt ? '0 : binCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      binCnt      <= '0;
      grayCnt     <= '0;
      activeSlice <= '0;
    end else begin
      if (strobes.clearCnt) activeSlice <= sliceSel;
      if (strobes.clearCnt || strobes.countEn) begin
        binCnt  <= binNext;
        grayCnt <= binNext ^ (binNext >> 1);
      end
    end
  end

  assign cntAtMax = (binCnt == BIN_MAX);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic syncA, syncB, syncC;
    logic captured;
    logic riseNow;
    logic [ENTRY_W-1:0] chStore [NUM_SLICES];

    assign riseNow = syncB && !syncC;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        syncC    <= 1'b0;
        captured <= 1'b0;
        for (int s = 0; s < NUM_SLICES; s++) chStore[s] <= '0;
      end else begin
        syncA <= cmpIn[ch];
        syncB <= syncA;
        syncC <= syncB;
        if (strobes.clearCnt) begin
          captured <= 1'b0;
        end else if (strobes.countEn && riseNow && !captured) begin
          captured             <= 1'b1;
          chStore[activeSlice] <= {1'b0, gainIn[ch], grayCnt};
        end else if (strobes.finish && !captured) begin
          chStore[activeSlice] <= {1'b1, gainIn[ch], GRAY_FULL};
        end
      end
    end

    assign rdEntries[ch] = chStore[rdSlice];
  end

  logic [ENTRY_W-1:0] rdSel;
  always_comb begin
    rdSel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdCh == CH_W'(c)) rdSel = rdEntries[c];
    end
  end

  assign rdCode = rdSel[CODE_W-1:0];
  assign rdGain = rdSel[CODE_W];
  assign rdOvf  = rdSel[CODE_W+1];
endmodule

// File: rtl/wilkinson_digitizer.sv
module wilkinson_digitizer
  import wadc_pkg::*;
#(
  parameter int CODE_W     = 12,
  parameter int NUM_CH     = 36,
  parameter int NUM_SLICES = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLICE_W   = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startConv,
  input  logic [SLICE_W-1:0] sliceSel,
  input  logic [NUM_CH-1:0]  cmpIn,
  input  logic [NUM_CH-1:0]  gainIn,
  input  logic [CH_W-1:0]    rdCh,
  input  logic [SLICE_W-1:0] rdSlice,
  output logic               convDone,
  output logic [CODE_W-1:0]  rdCode,
  output logic               rdGain,
  output logic               rdOvf
);
  wadcStrobes_t      strobes;
  logic              busy;
  logic              cntAtMax;
  logic              countEn;
  logic [CODE_W-1:0] grayCnt;

  assign countEn = strobes.countEn;

  wadc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startConv(startConv), .cntAtMax(cntAtMax),
    .strobes(strobes), .busy(busy), .convDone(convDone)
  );

  wadc_datapath #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .NUM_SLICES(NUM_SLICES),
    .CH_W(CH_W), .SLICE_W(SLICE_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sliceSel(sliceSel),
    .cmpIn(cmpIn), .gainIn(gainIn), .rdCh(rdCh), .rdSlice(rdSlice),
    .cntAtMax(cntAtMax), .grayCnt(grayCnt),
    .rdCode(rdCode), .rdGain(rdGain), .rdOvf(rdOvf)
  );
endmodule

// File: rtl/wadc_chk.sv
module wadc_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              startConv,
  input logic              busy,
  input logic              countEn,
  input logic              convDone,
  input logic [CODE_W-1:0] grayCnt,
  input logic [CODE_W-1:0] rdCode,
  input logic              rdOvf
);
  localparam logic [CODE_W-1:0] GRAY_FULL = {1'b1, {(CODE_W-1){1'b0}}};

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> (!busy && !countEn));

  // R7
  done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !convDone);

  // R3
  gray_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(grayCnt ^ $past(grayCnt)) <= 1));

  // R6
  ovf_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOvf |-> (rdCode == GRAY_FULL));

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startConv) |=> (busy || convDone));
endmodule

bind wilkinson_digitizer wadc_chk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .startConv(startConv), .busy(busy),
  .countEn(countEn), .convDone(convDone), .grayCnt(grayCnt),
  .rdCode(rdCode), .rdOvf(rdOvf)
);

// File: tb/tb_wilkinson_digitizer.sv
module tb_wilkinson_digitizer;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 4;
  localparam int NCH = 4;
  localparam int NSL = 2;
  localparam int FULL = (1 << CW) - 1;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startConv = 1'b0;
  logic [0:0]     sliceSel = '0;
  logic [NCH-1:0] cmpIn = '0;
  logic [NCH-1:0] gainIn = '0;
  logic [1:0]     rdCh = '0;
  logic [0:0]     rdSlice = '0;
  logic           convDone;
  logic [CW-1:0]  rdCode;
  logic           rdGain;
  logic           rdOvf;

  int nChecks = 0;
  int nFail = 0;
  int expCode [NSL][NCH];
  int expGain [NSL][NCH];
  int expOvf  [NSL][NCH];
  int fireT   [NCH];
  int gainV   [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  wilkinson_digitizer #(.CODE_W(CW), .NUM_CH(NCH), .NUM_SLICES(NSL)) dut (
    .clk(clk), .rstN(rstN), .startConv(startConv), .sliceSel(sliceSel),
    .cmpIn(cmpIn), .gainIn(gainIn), .rdCh(rdCh), .rdSlice(rdSlice),
    .convDone(convDone), .rdCode(rdCode), .rdGain(rdGain), .rdOvf(rdOvf)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int grayToBin(input int g);
    int b = 0;
    for (int i = CW - 1; i >= 0; i--) begin
      b |= ((((b >> (i + 1)) & 1) ^ ((g >> i) & 1)) << i);
    end
    return b;
  endfunction

  task automatic checkStore(input string tag);
    for (int s = 0; s < NSL; s++) begin
      for (int c = 0; c < NCH; c++) begin
        @(negedge clk);
        rdSlice = 1'(s);
        rdCh = 2'(c);
        #1;
        chk(tag, "decoded code", grayToBin(int'(rdCode)), expCode[s][c]);
        chk("R3", "raw gray code", int'(rdCode), expCode[s][c] ^ (expCode[s][c] >> 1));
        chk("R5", "gain flag", int'(rdGain), expGain[s][c]);
        chk("R6", "overflow mark", int'(rdOvf), expOvf[s][c]);
      end
    end
  endtask

  // Fire times count edges after start (start edge = 0); -1 means never fires
  task automatic runConv(input int slice, input bit preHigh, input bit restartMid);
    for (int c = 0; c < NCH; c++) gainIn[c] = gainV[c][0];
    if (preHigh) begin
      @(negedge clk);
      cmpIn[0] = 1'b1;
      repeat (3) @(negedge clk);
    end
    for (int j = 0; j <= 19; j++) begin
      @(negedge clk);
      if (j > 0) chk("R7", "done pulse", int'(convDone), (j - 1 == 16) ? 1 : 0);
      startConv = (j == 0) || (restartMid && j == 8);
      sliceSel = (restartMid && j == 8) ? 1'(slice ^ 1) : 1'(slice);
      for (int c = 0; c < NCH; c++) begin
        if (!(preHigh && c == 0) && fireT[c] >= 0) begin
          if (j == fireT[c]) cmpIn[c] = 1'b1;
          if (j == fireT[c] + 3) cmpIn[c] = 1'b0;
          if (j == fireT[c] + 5) cmpIn[c] = 1'b1;
        end
      end
    end
    @(negedge clk);
    startConv = 1'b0;
    cmpIn = '0;
    for (int c = 0; c < NCH; c++) begin
      bit none = (preHigh && c == 0) || fireT[c] < 0 || fireT[c] > FULL - 1;
      expCode[slice][c] = none ? FULL : fireT[c] + 1;
      expOvf[slice][c]  = none ? 1 : 0;
      expGain[slice][c] = gainV[c];
    end
    repeat (3) @(negedge clk);
    // R2 R4 R9 R10: stored rows, target slice only, first edge only
    checkStore("R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSL; s++)
      for (int c = 0; c < NCH; c++) begin
        expCode[s][c] = 0; expGain[s][c] = 0; expOvf[s][c] = 0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "done after reset", int'(convDone), 0);
    checkStore("R1");

    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < NCH; c++) begin
        fireT[c] = (k + c * 5) % 16;
        gainV[c] = (k >> c) & 1;
      end
      if (k % 4 == 3) fireT[3] = -1;
      runConv(k % 2, (k % 3 == 1), (k % 5 == 2));
    end

    // R10 and R6: all channels silent, channel 0 held high before start
    for (int c = 0; c < NCH; c++) begin
      fireT[c] = -1;
      gainV[c] = 1;
    end
    runConv(0, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule